// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This unit watches a running calendar and raises an alarm when the time agrees with a set of programmed alarm fields. There are six fields: second, minute, hour, date, month and day of week. Each alarm field is eight bits wide. Its top bit says whether that field takes part in the comparison, and its low seven bits hold the BCD value to match. The comparison is made only on the cycle that carries the one-second tick. So one matching second produces one alarm event, however many clock cycles that second lasts.

An event always sets a sticky alarm flag. The active-low interrupt pin then follows one of two modes. In single-event mode the pin is held low for as long as the flag is set. In pulsed mode every event drives the pin low for a fixed number of fast-tick periods (250 ms at the default rate). A later event restarts that count. Software clears the flag with a clear strobe. When auto-clear is selected, a read strobe of the status also clears it. The alarm is suppressed while the frequency output is on, and while the supply runs from the battery unless battery operation of the alarm has been allowed. The block has no streaming data path, so every pin is a plain level or single-cycle strobe, with no valid/ready handshake and no back-pressure.

Top module: `alarm_match_unit`

## Requirements
- R1: Alarm field k is `alarm_regs[8k+7:8k]`, in the order 0 = second, 1 = minute, 2 = hour, 3 = date, 4 = month, 5 = day of week. Bit 7 of a field enables it. Bits 6:0 are compared with `now_time[7k+6:7k]`. A field whose bit 7 is 0 does not affect the match.
- R2: If no field has its enable bit set, no event occurs.
- R3: A match is evaluated only on a cycle with `sec_tick` high. `alarm_flag` goes to 1 at the clock edge that samples that tick. A match held without a tick raises nothing.
- R4: With `pulse_mode`=0 (single event), `irq_n` is 0 exactly while `alarm_flag` is 1, unless suppressed.
- R5: With `pulse_mode`=1 (pulsed), each event drives `irq_n` to 0 for `PULSE_TICKS` (default 16) `fast_tick` pulses. It returns to 1 at the edge that samples the last of them. A new event reloads the full count.
- R6: `status_clr` clears `alarm_flag` at the next edge. An event in the same cycle wins, and the flag stays 1.
- R7: With `auto_clr`=1, `status_rd` clears `alarm_flag` like `status_clr`. With `auto_clr`=0, `status_rd` has no effect on it.
- R8: While `fout_en`=1, no event occurs and `irq_n` is held at 1.
- R9: While `on_battery`=1 and `batt_alarm_en`=0, no event occurs and `irq_n` is held at 1. With `batt_alarm_en`=1, the alarm works normally on battery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle strobe per calendar second |
| fast_tick | input | 1 | One-cycle strobe that times the pulse width |
| now_time | input | 42 | Current time, six 7-bit BCD fields |
| alarm_regs | input | 48 | Six 8-bit alarm fields, bit 7 of each enables it |
| pulse_mode | input | 1 | 0 = single event, 1 = pulsed |
| auto_clr | input | 1 | Status read clears the flag |
| fout_en | input | 1 | Frequency output active; suppresses the alarm |
| on_battery | input | 1 | Supply is on the backup battery |
| batt_alarm_en | input | 1 | Allow the alarm while on battery |
| status_rd | input | 1 | Status read strobe |
| status_clr | input | 1 | Software clear strobe for the flag |
| irq_n | output | 1 | Active-low interrupt |
| alarm_flag | output | 1 | Sticky alarm status |

## Verification
The in-design assertions check four rules on every cycle:
- the flag can only rise on a cycle that carried a second tick, and it never rises while the alarm is suppressed or no field is enabled;
- a clear with no event leaves the flag at 0;
- a reload of the pulse timer starts it at its full count;
- the timer never exceeds that count.

Only the bench scenarios can show the rest:
- that a disabled field really drops out of the comparison;
- the exact number of fast ticks in a pulse and its restart;
- which clear wins against a simultaneous event;
- how the interrupt pin behaves under each suppression condition.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int TIME_FW    = 7;
  localparam int ALARM_FW   = 8;
  localparam int TIME_W     = NUM_FIELDS * TIME_FW;
  localparam int ALARM_W    = NUM_FIELDS * ALARM_FW;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DATE  = 3'd3,
    FLD_MONTH = 3'd4,
    FLD_DOW   = 3'd5
  } field_idx_e;
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
  parameter int VAL_W = 7
) (
  input  logic [VAL_W:0]   alarm_f,
  input  logic [VAL_W-1:0] now_f,
  output logic             enabled,
  output logic             agrees
);
  // A disabled field always agrees, so it drops out of the AND (R1)
  always_comb begin
    enabled = alarm_f[VAL_W];
    agrees  = !enabled || (alarm_f[VAL_W-1:0] == now_f);
  end
endmodule

// File: rtl/alarm_pulse_timer.sv
module alarm_pulse_timer #(
  parameter int PULSE_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  input  logic flush,
  output logic active
);
  localparam int CW = $clog2(PULSE_TICKS + 1);
  localparam logic [CW-1:0] FULL = CW'(PULSE_TICKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) cnt <= '0;
    else if (load) cnt <= FULL;
    else if (tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);

  AST_RELOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !flush) |=> (cnt == FULL));  // R5

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);  // R5
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
  import alarm_pkg::*;
#(
  parameter int PULSE_TICKS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_tick,
  input  logic               fast_tick,
  input  logic [TIME_W-1:0]  now_time,
  input  logic [ALARM_W-1:0] alarm_regs,
  input  logic               pulse_mode,
  input  logic               auto_clr,
  input  logic               fout_en,
  input  logic               on_battery,
  input  logic               batt_alarm_en,
  input  logic               status_rd,
  input  logic               status_clr,
  output logic               irq_n,
  output logic               alarm_flag
);
  logic [NUM_FIELDS-1:0] fld_en;
  logic [NUM_FIELDS-1:0] fld_ok;

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_field
    alarm_field_cmp #(.VAL_W(TIME_FW)) u_cmp (
      .alarm_f (alarm_regs[k*ALARM_FW +: ALARM_FW]),
      .now_f   (now_time[k*TIME_FW +: TIME_FW]),
      .enabled (fld_en[k]),
      .agrees  (fld_ok[k])
    );
  end

  logic suppressed;
  logic hit;
  logic clr_req;
  logic status_q;
  logic pulse_active;

  always_comb begin
    suppressed = fout_en || (on_battery && !batt_alarm_en);
    hit        = sec_tick && (|fld_en) && (&fld_ok) && !suppressed;
    clr_req    = status_clr || (status_rd && auto_clr);
  end

  // The set has priority over a clear in the same cycle (R6)
  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= 1'b0;
    else if (hit) status_q <= 1'b1;
    else if (clr_req) status_q <= 1'b0;
  end

  alarm_pulse_timer #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (hit && pulse_mode),
    .tick   (fast_tick),
    .flush  (!pulse_mode || suppressed),
    .active (pulse_active)
  );

  always_comb begin
    alarm_flag = status_q;
    irq_n      = !((pulse_mode ? pulse_active : status_q) && !suppressed);
  end

  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q) |-> $past(sec_tick));  // R3

  AST_NO_EN_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_q && !(|fld_en)) |=> !status_q);  // R2

  AST_SUPPRESS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_q && suppressed) |=> !status_q);  // R8

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_clr && !hit) |=> !status_q);  // R6
endmodule

// File: tb/tb_alarm_match_unit.sv
module tb_alarm_match_unit;
  logic clk = 0, rst_n = 0;
  logic sec_tick = 0, fast_tick = 0;
  logic [41:0] now_time = '0;
  logic [47:0] alarm_regs = '0;
  logic pulse_mode = 0, auto_clr = 0, fout_en = 0, on_battery = 0, batt_alarm_en = 0;
  logic status_rd = 0, status_clr = 0;
  logic irq_n, alarm_flag;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  alarm_match_unit dut (.*);

  function automatic logic [41:0] tm(input logic [6:0] s, mi, h, d, mo, w);
    return {w, mo, d, h, mi, s};
  endfunction
  function automatic logic [47:0] al(input logic [7:0] s, mi, h, d, mo, w);
    return {w, mo, d, h, mi, s};
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick_sec();
    @(negedge clk) sec_tick = 1;
    @(negedge clk) sec_tick = 0;
  endtask
  task automatic tick_fast();
    @(negedge clk) fast_tick = 1;
    @(negedge clk) fast_tick = 0;
  endtask
  task automatic clr_flag();
    @(negedge clk) status_clr = 1;
    @(negedge clk) status_clr = 0;
  endtask

  task automatic t_reset();
    chk(irq_n, 1'b1, "reset irq_n");
    chk(alarm_flag, 1'b0, "reset alarm_flag");
  endtask

  task automatic t_r1_fields();
    alarm_regs = al(8'h80 | 8'h30, 8'h80 | 8'h15, 8'h09, 8'h00, 8'h00, 8'h00);
    now_time = tm(7'h30, 7'h15, 7'h22, 7'h01, 7'h01, 7'h03);
    tick_sec();
    chk(alarm_flag, 1'b1, "R1 enabled match, disabled hour ignored");
    clr_flag();
    now_time = tm(7'h30, 7'h16, 7'h22, 7'h01, 7'h01, 7'h03);
    tick_sec();
    chk(alarm_flag, 1'b0, "R1 enabled minute mismatch");
    alarm_regs = al(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h83);
    tick_sec();
    chk(alarm_flag, 1'b1, "R1 day-of-week field");
    clr_flag();
  endtask

  task automatic t_r2_none();
    alarm_regs = '0;
    tick_sec();
    chk(alarm_flag, 1'b0, "R2 no field enabled");
    chk(irq_n, 1'b1, "R2 irq idle");
  endtask

  task automatic t_r3_tick();
    alarm_regs = al(8'hA0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    now_time = tm(7'h20, 7'h00, 7'h00, 7'h01, 7'h01, 7'h01);
    repeat (5) @(negedge clk);
    chk(alarm_flag, 1'b0, "R3 no tick no event");
    @(negedge clk) sec_tick = 1;
    @(negedge clk) sec_tick = 0;
    chk(alarm_flag, 1'b1, "R3 flag one edge after tick");
  endtask

  task automatic t_r4_single();
    repeat (20) @(negedge clk);
    chk(irq_n, 1'b0, "R4 irq held low");
    clr_flag();
    chk(irq_n, 1'b1, "R4 irq releases on clear");
  endtask

  task automatic t_r6_r7_clear();
    @(negedge clk) begin sec_tick = 1; status_clr = 1; end
    @(negedge clk) begin sec_tick = 0; status_clr = 0; end
    chk(alarm_flag, 1'b1, "R6 set beats clear");
    auto_clr = 0;
    @(negedge clk) status_rd = 1;
    @(negedge clk) status_rd = 0;
    chk(alarm_flag, 1'b1, "R7 read without auto-clear");
    auto_clr = 1;
    @(negedge clk) status_rd = 1;
    @(negedge clk) status_rd = 0;
    chk(alarm_flag, 1'b0, "R7 read with auto-clear");
    auto_clr = 0;
  endtask

  task automatic t_r5_pulse();
    pulse_mode = 1;
    tick_sec();
    chk(irq_n, 1'b0, "R5 pulse starts");
    repeat (10) tick_fast();
    tick_sec();
    repeat (15) tick_fast();
    chk(irq_n, 1'b0, "R5 reload, low after 15 ticks");
    tick_fast();
    chk(irq_n, 1'b1, "R5 high after 16 ticks");
    chk(alarm_flag, 1'b1, "R5 flag stays set");
    clr_flag();
    pulse_mode = 0;
  endtask

  task automatic t_r8_fout();
    fout_en = 1;
    tick_sec();
    chk(alarm_flag, 1'b0, "R8 no event with fout");
    fout_en = 0;
    tick_sec();
    fout_en = 1;
    @(negedge clk);
    chk(irq_n, 1'b1, "R8 irq masked with fout");
    fout_en = 0;
    @(negedge clk);
    chk(irq_n, 1'b0, "R8 irq returns");
    clr_flag();
  endtask

  task automatic t_r9_batt();
    on_battery = 1; batt_alarm_en = 0;
    tick_sec();
    chk(alarm_flag, 1'b0, "R9 blocked on battery");
    chk(irq_n, 1'b1, "R9 irq high on battery");
    batt_alarm_en = 1;
    tick_sec();
    chk(alarm_flag, 1'b1, "R9 allowed on battery");
    chk(irq_n, 1'b0, "R9 irq low on battery");
    on_battery = 0; batt_alarm_en = 0;
    clr_flag();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_r1_fields();
    t_r2_none();
    t_r3_tick();
    t_r4_single();
    t_r6_r7_clear();
    t_r5_pulse();
    t_r8_fout();
    t_r9_batt();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule